// File: doc/BRIEF.md
# Optical Black Clamp Loop Controller

This block closes a digital black-level loop for an image sensor front end. On every line a window pulse marks the shielded (optically black) pixels. While that window is open, each valid ADC sample is compared with a programmable black-level target, and the difference is summed. When an update period ends, which is one line by default or several lines when programmed, the accumulated error is averaged over the number of samples that contributed. A first-order IIR step then applies the average to a saturating correction code, and that code drives an offset DAC placed ahead of the converter.

The target is a 10-bit code in quarter-LSB units, so it covers 0 to 255.75 LSB of the 12-bit converter. While the loop is switched off, the correction output simply follows the target code as a fixed offset. When the loop is switched back on, it starts from that offset. A control state machine has four states. `ST_OFF` is the loop-disabled state. `ST_COLLECT` gathers error while waiting for the end of a period. `ST_DIVIDE` runs a bit-serial division of the sum by the sample count. `ST_APPLY` writes the filtered correction. The transitions are:
- enable (OFF→COLLECT);
- period end with samples (COLLECT→DIVIDE);
- empty period (COLLECT→COLLECT, discarded);
- divide done (DIVIDE→APPLY);
- apply (APPLY→COLLECT);
- disable (any state→OFF).

Top module: `obc_clamp_loop`

## Requirements
- R1: During and directly after reset, `dac_code` is 0 and `dac_updated` is 0.
- R2: While `loop_en` is 0, `dac_code` equals the `target_code` of the previous clock, and `dac_updated` never pulses.
- R3: Each sample taken with `pix_valid`=1 and `ob_window`=1 contributes an error of 4×`pix_data` − `target_code`, in quarter-LSB units.
- R4: Samples with `ob_window`=0, and cycles with `pix_valid`=0, add nothing to the error or to the count.
- R5: The line error is the summed error divided by the sample count, truncated toward zero.
- R6: On each update the new code is the old code plus (line error arithmetically shifted right by `filt_shift`, 0 to 7).
- R7: The new code saturates at 0 and at 1023.
- R8: An update period ends on the `line_start` pulse that completes `rate_div`+1 line starts since the previous period end. All windows within the period are accumulated together.
- R9: A period that contains no counted sample leaves `dac_code` unchanged and raises no `dac_updated` pulse.
- R10: `dac_updated` is high for exactly one clock, in the same cycle the new code first appears. While the loop is enabled, `dac_code` changes at no other time.
- R11: Within one period, at most 1023 samples are counted. Samples beyond that are ignored.
- R12: When `loop_en` rises, the correction starts from the target code that was in effect while the loop was off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loop_en | input | 1 | 1 = closed loop, 0 = fixed offset from target |
| pix_valid | input | 1 | Sample strobe for `pix_data` |
| pix_data | input | 12 | ADC sample, straight binary |
| ob_window | input | 1 | High during the optical black pixels |
| line_start | input | 1 | One-clock pulse at the start of each line |
| target_code | input | 10 | Black-level target in quarter-LSB units |
| filt_shift | input | 3 | IIR gain shift K (step = error >>> K) |
| rate_div | input | 4 | Update every `rate_div`+1 lines |
| dac_code | output | 10 | Offset DAC correction code |
| dac_updated | output | 1 | One-clock pulse after each loop update |

## Verification
The assertions assume that `loop_en` and `target_code` are sampled synchronously. They also assume that a period ends only after the previous division and apply step (about 28 clocks) have completed, and that a window sample never falls in the same clock as `line_start`. The stimulus keeps to these limits. Each line ends with a separate `line_start` cycle, and after every period end the bench waits for the update pulse, or for a fixed quiet interval, before it drives the next window. The sweeps run every filter shift against sample sets that sit above and below the target, with counts chosen so that the division truncates.

// File: rtl/obc_pkg.sv
package obc_pkg;

    // Control states of the clamp loop sequencer
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DIVIDE  = 2'd2,
        ST_APPLY   = 2'd3
    } obc_state_t;

endpackage

// File: rtl/obc_accum.sv
module obc_accum #(
    parameter int ERR_W = 15,
    parameter int CNT_W = 10,
    parameter int SUM_W = ERR_W + CNT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    sample_i,
    input  logic signed [ERR_W-1:0] err_i,
    output logic signed [SUM_W-1:0] sum_o,
    output logic [CNT_W-1:0]        cnt_o
);

    logic signed [SUM_W-1:0] sum_q;
    logic [CNT_W-1:0]        cnt_q;
    logic signed [SUM_W-1:0] err_ext;
    logic                    full;
    logic                    take;

    always_comb begin
        err_ext = {{(SUM_W-ERR_W){err_i[ERR_W-1]}}, err_i};
        full    = (cnt_q == {CNT_W{1'b1}});
        take    = sample_i && !full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (clear_i) begin
            sum_q <= sample_i ? err_ext : '0;
            cnt_q <= sample_i ? CNT_W'(1) : '0;
        end else if (take) begin
            sum_q <= sum_q + err_ext;
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign sum_o = sum_q;
    assign cnt_o = cnt_q;

endmodule

// File: rtl/obc_divider.sv
module obc_divider #(
    parameter int NUM_W = 25,
    parameter int DEN_W = 10,
    parameter int QUO_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [QUO_W-1:0] quo_o
);

    localparam int ITER_W = $clog2(NUM_W + 1);

    logic [DEN_W:0]    rem_q;
    logic [NUM_W-1:0]  quo_q;
    logic [DEN_W-1:0]  den_q;
    logic [ITER_W-1:0] iter_q;
    logic              done_q;

    logic [DEN_W:0]    rem_sh;
    logic [DEN_W:0]    rem_nx;
    logic              ge;

    // One restoring step per clock, most significant dividend bit first
    always_comb begin
        rem_sh = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
        ge     = (rem_sh >= {1'b0, den_q});
        rem_nx = ge ? (rem_sh - {1'b0, den_q}) : rem_sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            iter_q <= '0;
            done_q <= 1'b0;
        end else if (start_i) begin
            rem_q  <= '0;
            quo_q  <= num_i;
            den_q  <= den_i;
            iter_q <= ITER_W'(NUM_W);
            done_q <= 1'b0;
        end else if (iter_q != '0) begin
            rem_q  <= rem_nx;
            quo_q  <= {quo_q[NUM_W-2:0], ge};
            iter_q <= iter_q - ITER_W'(1);
            done_q <= (iter_q == ITER_W'(1));
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done_o = done_q;
    assign quo_o  = quo_q[QUO_W-1:0];

endmodule

// File: rtl/obc_filter.sv
module obc_filter #(
    parameter int ERR_W   = 15,
    parameter int DAC_W   = 10,
    parameter int SHIFT_W = 3
) (
    input  logic [DAC_W-1:0]        corr_i,
    input  logic signed [ERR_W-1:0] err_i,
    input  logic [SHIFT_W-1:0]      shift_i,
    output logic [DAC_W-1:0]        corr_o
);

    localparam int WIDE_W = ((ERR_W > DAC_W) ? ERR_W : DAC_W) + 2;
    localparam logic signed [WIDE_W-1:0] CODE_MAX =
        {{(WIDE_W-DAC_W){1'b0}}, {DAC_W{1'b1}}};

    logic signed [ERR_W-1:0]  step;
    logic signed [WIDE_W-1:0] corr_ext;
    logic signed [WIDE_W-1:0] step_ext;
    logic signed [WIDE_W-1:0] total;

    always_comb begin
        step     = err_i >>> shift_i;
        corr_ext = {{(WIDE_W-DAC_W){1'b0}}, corr_i};
        step_ext = {{(WIDE_W-ERR_W){step[ERR_W-1]}}, step};
        total    = corr_ext + step_ext;
        if (total < 0) begin
            corr_o = '0;
        end else if (total > CODE_MAX) begin
            corr_o = {DAC_W{1'b1}};
        end else begin
            corr_o = total[DAC_W-1:0];
        end
    end

endmodule

// File: rtl/obc_clamp_loop.sv
module obc_clamp_loop
    import obc_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int TARGET_W = 10,
    parameter int CNT_W    = 10,
    parameter int RATE_W   = 4,
    parameter int SHIFT_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                loop_en,
    input  logic                pix_valid,
    input  logic [SAMPLE_W-1:0] pix_data,
    input  logic                ob_window,
    input  logic                line_start,
    input  logic [TARGET_W-1:0] target_code,
    input  logic [SHIFT_W-1:0]  filt_shift,
    input  logic [RATE_W-1:0]   rate_div,
    output logic [TARGET_W-1:0] dac_code,
    output logic                dac_updated
);

    localparam int ERR_W = SAMPLE_W + 3;
    localparam int SUM_W = ERR_W + CNT_W;
    localparam int DAC_W = TARGET_W;

    obc_state_t state_q, state_d;

    logic signed [ERR_W-1:0] err_c;
    logic                    in_win;
    logic [RATE_W-1:0]       lc_q;
    logic                    period_end;
    logic                    acc_clear;
    logic signed [SUM_W-1:0] sum_w;
    logic [CNT_W-1:0]        cnt_w;
    logic [SUM_W-1:0]        sum_mag;
    logic                    div_start;
    logic                    div_done;
    logic [ERR_W-1:0]        quo_w;
    logic                    neg_q;
    logic signed [ERR_W-1:0] line_err;
    logic [DAC_W-1:0]        corr_q;
    logic [DAC_W-1:0]        corr_next;
    logic                    load_corr;
    logic                    upd_q;

    // Per-sample error in quarter-LSB units
    always_comb begin
        err_c  = $signed({1'b0, pix_data, 2'b00})
               - $signed({{(ERR_W-TARGET_W){1'b0}}, target_code});
        in_win = loop_en && pix_valid && ob_window;
    end

    // Line counter marking the end of each update period
    always_comb begin
        period_end = loop_en && line_start && (lc_q >= rate_div);
        acc_clear  = !loop_en || period_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lc_q <= '0;
        end else if (!loop_en) begin
            lc_q <= '0;
        end else if (line_start) begin
            lc_q <= period_end ? '0 : lc_q + RATE_W'(1);
        end
    end

    obc_accum #(
        .ERR_W (ERR_W),
        .CNT_W (CNT_W),
        .SUM_W (SUM_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (acc_clear),
        .sample_i (in_win),
        .err_i    (err_c),
        .sum_o    (sum_w),
        .cnt_o    (cnt_w)
    );

    always_comb begin
        sum_mag = sum_w[SUM_W-1] ? SUM_W'(-sum_w) : SUM_W'(sum_w);
    end

    obc_divider #(
        .NUM_W (SUM_W),
        .DEN_W (CNT_W),
        .QUO_W (ERR_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (sum_mag),
        .den_i   (cnt_w),
        .done_o  (div_done),
        .quo_o   (quo_w)
    );

    // Sign of the sum is held while the divider works on its magnitude
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_q <= 1'b0;
        end else if (div_start) begin
            neg_q <= sum_w[SUM_W-1];
        end
    end

    always_comb begin
        line_err = neg_q ? -$signed(quo_w) : $signed(quo_w);
    end

    obc_filter #(
        .ERR_W   (ERR_W),
        .DAC_W   (DAC_W),
        .SHIFT_W (SHIFT_W)
    ) u_filt (
        .corr_i  (corr_q),
        .err_i   (line_err),
        .shift_i (filt_shift),
        .corr_o  (corr_next)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (loop_en) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (!loop_en) begin
                    state_d = ST_OFF;
                end else if (period_end && (cnt_w != '0)) begin
                    state_d = ST_DIVIDE;
                end
            end
            ST_DIVIDE: begin
                if (!loop_en) begin
                    state_d = ST_OFF;
                end else if (div_done) begin
                    state_d = ST_APPLY;
                end
            end
            ST_APPLY: begin
                state_d = loop_en ? ST_COLLECT : ST_OFF;
            end
        endcase
    end

    // Control outputs of the sequencer
    always_comb begin
        div_start = 1'b0;
        load_corr = 1'b0;
        unique case (state_q)
            ST_OFF:     ;
            ST_COLLECT: div_start = loop_en && period_end && (cnt_w != '0);
            ST_DIVIDE:  ;
            ST_APPLY:   load_corr = loop_en;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            corr_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= load_corr;
            if (!loop_en) begin
                corr_q <= target_code;
            end else if (load_corr) begin
                corr_q <= corr_next;
            end
        end
    end

    assign dac_code    = corr_q;
    assign dac_updated = upd_q;

endmodule

// File: rtl/obc_clamp_loop_chk.sv
module obc_clamp_loop_chk #(
    parameter int TARGET_W = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                loop_en,
    input logic [TARGET_W-1:0] target_code,
    input logic [TARGET_W-1:0] dac_code,
    input logic                dac_updated
);

    // R2: with the loop off, the code follows the target one clock later
    a_r2_off_follows_target: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(loop_en)) |-> (dac_code == $past(target_code)));

    // R2: no update pulse unless the loop was enabled
    a_r2_no_pulse_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        dac_updated |-> $past(loop_en));

    // R10: the update flag lasts one clock
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dac_updated |=> !dac_updated);

    // R10: with the loop on, the code moves only together with the flag
    a_r10_hold_between_updates: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(loop_en) && !dac_updated) |-> (dac_code == $past(dac_code)));

endmodule

bind obc_clamp_loop obc_clamp_loop_chk #(
    .TARGET_W (TARGET_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .loop_en     (loop_en),
    .target_code (target_code),
    .dac_code    (dac_code),
    .dac_updated (dac_updated)
);

// File: tb/obc_clamp_loop_tb.sv
module obc_clamp_loop_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loop_en = 1'b0;
    logic        pix_valid = 1'b0;
    logic [11:0] pix_data = '0;
    logic        ob_window = 1'b0;
    logic        line_start = 1'b0;
    logic [9:0]  target_code = '0;
    logic [2:0]  filt_shift = '0;
    logic [3:0]  rate_div = '0;
    logic [9:0]  dac_code;
    logic        dac_updated;

    int checks = 0;
    int errors = 0;
    int exp_code = 0;
    int acc_sum = 0;
    int acc_cnt = 0;
    int lc = 0;
    int kk = 0;
    int rate = 0;
    int target = 0;

    always #4 clk = ~clk;

    obc_clamp_loop u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .loop_en     (loop_en),
        .pix_valid   (pix_valid),
        .pix_data    (pix_data),
        .ob_window   (ob_window),
        .line_start  (line_start),
        .target_code (target_code),
        .filt_shift  (filt_shift),
        .rate_div    (rate_div),
        .dac_code    (dac_code),
        .dac_updated (dac_updated)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_target(input int t);
        target = t;
        @(negedge clk);
        target_code = 10'(t);
    endtask

    // One line: ignored samples, window of n samples, then line_start
    task automatic run_line(input int n, input int base, input int stride);
        int got;
        int avg;
        int step;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            pix_valid = 1'b1; ob_window = 1'b0; pix_data = 12'hFFF;   // R4
        end
        for (int i = 0; i < n; i++) begin
            int v;
            v = (base + i * stride) % 4096;
            @(negedge clk);
            pix_valid = 1'b1; ob_window = 1'b1; pix_data = 12'(v);
            if (acc_cnt < 1023) begin                                 // R11
                acc_sum += 4 * v - target;                            // R3
                acc_cnt++;
            end
            @(negedge clk);
            pix_valid = 1'b0; ob_window = 1'b1; pix_data = 12'hFFF;   // R4
        end
        @(negedge clk);
        pix_valid = 1'b0; ob_window = 1'b0;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        lc++;
        if (lc > rate) begin
            lc = 0;
            if (acc_cnt > 0) begin
                avg  = acc_sum / acc_cnt;                             // R5
                step = avg >>> kk;                                    // R6
                exp_code = exp_code + step;
                if (exp_code < 0) exp_code = 0;                       // R7
                if (exp_code > 1023) exp_code = 1023;
                got = 0;
                for (int c = 0; c < 100; c++) begin
                    @(negedge clk);
                    if (dac_updated) begin
                        got = 1;
                        break;
                    end
                end
                check(got == 1, "R8 update pulse", got, 1);
                check(int'(dac_code) == exp_code, "R6/R7 new code", int'(dac_code), exp_code);
                @(negedge clk);
                check(dac_updated == 1'b0, "R10 single pulse", int'(dac_updated), 0);
            end else begin
                got = 0;
                for (int c = 0; c < 40; c++) begin
                    @(negedge clk);
                    if (dac_updated) got++;
                end
                check(got == 0, "R9 empty period no pulse", got, 0);
                check(int'(dac_code) == exp_code, "R9 code held", int'(dac_code), exp_code);
            end
            acc_sum = 0;
            acc_cnt = 0;
        end else begin
            got = 0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (dac_updated) got++;
            end
            check(got == 0, "R8 no update mid-period", got, 0);
            check(int'(dac_code) == exp_code, "R8 code held mid-period", int'(dac_code), exp_code);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int nlist[4];
        int got;
        nlist = '{1, 3, 7, 20};
        repeat (3) @(negedge clk);
        check(dac_code == 10'd0, "R1 reset code", int'(dac_code), 0);
        check(dac_updated == 1'b0, "R1 reset flag", int'(dac_updated), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dac_code == 10'd0, "R1 code after reset", int'(dac_code), 0);

        // R2: loop off, fixed offset
        set_target(300);
        @(negedge clk);
        check(int'(dac_code) == 300, "R2 fixed offset", int'(dac_code), 300);
        set_target(517);
        @(negedge clk);
        check(int'(dac_code) == 517, "R2 fixed offset", int'(dac_code), 517);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            pix_valid = 1'b1; ob_window = 1'b1; pix_data = 12'd4000;
        end
        @(negedge clk);
        pix_valid = 1'b0; ob_window = 1'b0; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        got = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (dac_updated) got++;
        end
        check(got == 0, "R2 no pulse when off", got, 0);
        check(int'(dac_code) == 517, "R2 code stays at target", int'(dac_code), 517);

        // R12: enable starts from the target
        set_target(512);
        @(negedge clk);
        loop_en = 1'b1;
        exp_code = 512;
        @(negedge clk);
        check(int'(dac_code) == 512, "R12 start from target", int'(dac_code), 512);

        // R3 R5 R6: sweep every shift against several sample sets
        for (int k = 0; k < 8; k++) begin
            kk = k;
            @(negedge clk);
            filt_shift = 3'(k);
            for (int p = 0; p < 4; p++) begin
                run_line(nlist[p], 90 + ((k * 4 + p) * 13) % 80, p + 1);
            end
        end

        // R7: saturation at both ends
        kk = 0;
        @(negedge clk);
        filt_shift = 3'd0;
        set_target(1023);
        run_line(4, 4095, 0);
        run_line(4, 0, 0);
        run_line(4, 0, 0);

        // R8: update every third line
        set_target(512);
        kk = 1;
        rate = 2;
        @(negedge clk);
        filt_shift = 3'd1;
        rate_div = 4'd2;
        run_line(5, 150, 2);
        run_line(5, 140, 3);
        run_line(5, 160, 1);

        // R9: empty period
        rate = 0;
        @(negedge clk);
        rate_div = 4'd0;
        run_line(0, 0, 0);

        // R11: count limit
        kk = 3;
        @(negedge clk);
        filt_shift = 3'd3;
        run_line(1100, 0, 1);

        // R12: re-enable from a new target
        @(negedge clk);
        loop_en = 1'b0;
        set_target(200);
        @(negedge clk);
        check(int'(dac_code) == 200, "R2 fixed offset after disable", int'(dac_code), 200);
        loop_en = 1'b1;
        exp_code = 200;
        lc = 0;
        acc_sum = 0;
        acc_cnt = 0;
        @(negedge clk);
        check(int'(dac_code) == 200, "R12 restart value", int'(dac_code), 200);
        run_line(6, 60, 4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule